// File: doc/BRIEF.md
# Paged I2C EEPROM Slave Write Engine

This block is an I2C slave placed in front of an on-chip byte store organised in pages of 64 bytes. The 8-bit page index and the 6-bit in-page offset come from the word address that follows the device address. It over-samples SCL and SDA with the system clock and recognises START and STOP. After the device address it takes two word-address bytes, then collects data bytes into a page buffer. The collected bytes reach the store only when the master issues STOP. STOP starts an internal write cycle that lasts `WR_CYCLES` system clocks. During that cycle the slave answers no device address, so a master can poll until it gets an acknowledge.

A write-protect input is captured once per write, on the SCL falling edge that ends the acknowledge of the low word-address byte. If that capture is high, the first data byte is refused and the request is dropped. A single-byte random read lets the contents be observed: a write header with no data, a repeated START, the read address, one byte, a master NACK and STOP. The storage holds `2**MEM_PAGE_W` pages. Page-index bits above that width are decoded but alias onto the stored pages. `WR_CYCLES` must be at least 64, because the commit moves one buffer slot per clock.

The control state machine has these states:
- IDLE: the bus is free.
- DEV: shifting in the device address. DEV_ACK: answers the device address.
- AHI and AHI_ACK: the high word-address byte and its acknowledge.
- ALO and ALO_ACK: the low word-address byte and its acknowledge.
- WDAT and WDAT_ACK: a data byte and its acknowledge.
- RDAT: shifting a byte out. RDAT_ACK: the master's acknowledge bit.
- SKIP: ignore the bus until the next START or STOP.

The transitions are:
- START from any state goes to DEV. STOP from any state goes to IDLE.
- DEV goes to DEV_ACK after 8 bits. DEV_ACK goes to SKIP on a NACK, to RDAT when reading, and to AHI when writing.
- AHI goes to AHI_ACK, then ALO. ALO goes to ALO_ACK, then WDAT.
- WDAT goes to WDAT_ACK. WDAT_ACK goes back to WDAT after an acknowledge, or to SKIP after a refusal.
- RDAT goes to RDAT_ACK, then SKIP.

Top module: `i2c_page_eeprom`

## Requirements
- R1: After reset every stored byte reads FFh and SDA is released (`sda_low_o` = 0).
- R2: The device address byte is acknowledged only when its upper seven bits equal 1010 followed by `DEV_SEL`; bit 0 is R/W (0 write, 1 read); any other address leaves SDA released.
- R3: In a write the slave acknowledges the device address, both word-address bytes and every accepted data byte.
- R4: The word address is high byte then low byte; high bits 7:6 are ignored, high bits 5:0 with low bits 7:6 form the page index, low bits 5:0 form the offset.
- R5: Loaded bytes reach the store only at STOP; before STOP a read shows the old contents, and a sequence closed by a repeated START commits nothing.
- R6: After each data byte only the 6-bit offset increments, wrapping 63 to 0 within the same page; a slot loaded twice keeps the later byte.
- R7: Slots not loaded in the committed sequence keep their previous contents.
- R8: For `WR_CYCLES` clocks after a committing STOP, every device address (read or write) is not acknowledged; afterwards the address is acknowledged again.
- R9: Write protect is captured on the SCL falling edge that ends the low word-address acknowledge; if high, the first data byte is not acknowledged, nothing is written and no write cycle starts.
- R10: Changes of write protect after that capture do not affect the current write.
- R11: A random read returns the stored byte at the loaded word address, MSB first.
- R12: A STOP with no data byte loaded starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| wp_i | input | 1 | Write protect, active high |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Every cycle, the assertions check three things:
- SDA stays released while the machine is idle or skipping, and in any acknowledge slot of a busy or protected request.
- No byte is pushed into the buffer and no commit starts while a write cycle runs.
- The page index stays fixed while data bytes are pushed.

Only the bench scenarios show the rest:
- which data ends up in which slot: offset wrap, the later byte winning, and untouched slots;
- the lost write when a repeated START closes the sequence;
- the length of the polling window;
- the exact capture point of write protect.

// File: rtl/i2cpe_pkg.sv
package i2cpe_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK, ST_ALO, ST_ALO_ACK,
        ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK, ST_SKIP
    } link_state_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2cpe_sync.sv
module i2cpe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], d};
    end

    assign q    = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/i2cpe_link.sv
module i2cpe_link
    import i2cpe_pkg::*;
#(
    parameter logic [2:0] DEV_SEL   = 3'b000,
    parameter int         PAGE_W    = 8,
    parameter int         OFF_W     = 6,
    parameter int         STORE_PW  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                sda,
    input  logic                start_c,
    input  logic                stop_c,
    input  logic                wp_i,
    input  logic                busy_i,
    input  logic [7:0]          rd_data_i,
    output logic                sda_low_o,
    output logic [STORE_PW-1:0] page_o,
    output logic [OFF_W-1:0]    off_o,
    output logic                push_o,
    output logic [OFF_W-1:0]    push_off_o,
    output logic [7:0]          push_data_o,
    output logic                clear_o,
    output logic                commit_o
);
    localparam int AW   = PAGE_W + OFF_W;
    localparam int HI_W = AW - 8;
    localparam logic [OFF_W-1:0] OFF_ONE = 1;

    link_state_t    state;
    logic [3:0]     bitcnt;
    logic [7:0]     shreg;
    logic [AW-1:0]  waddr;
    logic           ack_q, rw_q, wp_q, first_dat, loaded;
    logic           full;

    assign full   = (bitcnt == 4'd8);
    assign page_o = waddr[OFF_W +: STORE_PW];
    assign off_o  = waddr[OFF_W-1:0];

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE; bitcnt <= '0; shreg <= '0; waddr <= '0;
            ack_q <= 1'b0; rw_q <= 1'b0; wp_q <= 1'b0; first_dat <= 1'b0;
            loaded <= 1'b0; push_o <= 1'b0; push_off_o <= '0;
            push_data_o <= '0; clear_o <= 1'b0; commit_o <= 1'b0;
        end else begin
            push_o   <= 1'b0;
            clear_o  <= 1'b0;
            commit_o <= 1'b0;
            if (start_c) begin
                state   <= ST_DEV;
                bitcnt  <= '0;
                loaded  <= 1'b0;
                clear_o <= 1'b1;
            end else if (stop_c) begin
                state    <= ST_IDLE;
                commit_o <= loaded;
                loaded   <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: ;
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (scl_rise && !full) begin
                            shreg  <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && full) begin
                            ack_q <= 1'b1;
                            unique case (state)
                                ST_DEV: begin
                                    ack_q <= (shreg[7:1] == {DEV_PREFIX, DEV_SEL}) && !busy_i;
                                    rw_q  <= shreg[0];
                                    state <= ST_DEV_ACK;
                                end
                                ST_AHI: begin
                                    waddr[AW-1:8] <= shreg[HI_W-1:0];
                                    state <= ST_AHI_ACK;
                                end
                                ST_ALO: begin
                                    waddr[7:0] <= shreg;
                                    state <= ST_ALO_ACK;
                                end
                                default: begin
                                    state <= ST_WDAT_ACK;
                                    if (first_dat && wp_q) begin
                                        ack_q  <= 1'b0;
                                        loaded <= 1'b0;
                                    end else begin
                                        push_o      <= 1'b1;
                                        push_off_o  <= waddr[OFF_W-1:0];
                                        push_data_o <= shreg;
                                        loaded      <= 1'b1;
                                        waddr[OFF_W-1:0] <= waddr[OFF_W-1:0] + OFF_ONE;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            ack_q  <= 1'b0;
                            unique case (state)
                                ST_DEV_ACK: begin
                                    if (!ack_q)    state <= ST_SKIP;
                                    else if (rw_q) begin
                                        state <= ST_RDAT;
                                        shreg <= rd_data_i;
                                    end else       state <= ST_AHI;
                                end
                                ST_AHI_ACK: state <= ST_ALO;
                                ST_ALO_ACK: begin
                                    state     <= ST_WDAT;
                                    wp_q      <= wp_i;
                                    first_dat <= 1'b1;
                                end
                                default: begin
                                    state     <= ack_q ? ST_WDAT : ST_SKIP;
                                    first_dat <= 1'b0;
                                end
                            endcase
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise && !full) bitcnt <= bitcnt + 4'd1;
                        else if (scl_fall) begin
                            if (full) state <= ST_RDAT_ACK;
                            else      shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                    ST_RDAT_ACK: if (scl_fall) state <= ST_SKIP;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_low_o = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_low_o = ack_q;
            ST_RDAT: sda_low_o = ~shreg[7];
            default: sda_low_o = 1'b0;
        endcase
    end

    assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_low_o);
    assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK && busy_i) |-> !sda_low_o);
    assert_wp_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDAT_ACK && first_dat && wp_q) |-> !sda_low_o);
    assert_page_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $stable(waddr[AW-1:OFF_W]));
endmodule

// File: rtl/i2cpe_store.sv
module i2cpe_store #(
    parameter int OFF_W      = 6,
    parameter int MEM_PAGE_W = 4,
    parameter int WR_CYCLES  = 600
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [OFF_W-1:0]      push_off_i,
    input  logic [7:0]            push_data_i,
    input  logic                  clear_i,
    input  logic                  commit_i,
    input  logic [MEM_PAGE_W-1:0] page_i,
    input  logic [OFF_W-1:0]      off_i,
    output logic [7:0]            rd_data_o,
    output logic                  busy_o
);
    localparam int PG_BYTES  = 1 << OFF_W;
    localparam int MEM_DEPTH = PG_BYTES << MEM_PAGE_W;
    localparam int CW        = $clog2(WR_CYCLES + 1);

    logic [7:0]            pbuf [PG_BYTES];
    logic [PG_BYTES-1:0]   pval;
    logic [7:0]            mem  [MEM_DEPTH];
    logic [CW-1:0]         tmr, elapsed;
    logic [MEM_PAGE_W-1:0] cpage;
    logic [OFF_W-1:0]      widx;
    logic                  wr_en;

    assign busy_o    = (tmr != '0);
    assign elapsed   = CW'(WR_CYCLES) - tmr;
    assign widx      = elapsed[OFF_W-1:0];
    assign wr_en     = busy_o && (elapsed < CW'(PG_BYTES)) && pval[widx];
    assign rd_data_o = mem[{page_i, off_i}];

    always_ff @(posedge clk) begin
        if (push_i) pbuf[push_off_i] <= push_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pval  <= '0;
            tmr   <= '0;
            cpage <= '0;
        end else begin
            if ((clear_i && !busy_o) || (tmr == CW'(1))) pval <= '0;
            else if (push_i)                             pval[push_off_i] <= 1'b1;
            if (commit_i) begin
                tmr   <= CW'(WR_CYCLES);
                cpage <= page_i;
            end else if (busy_o) begin
                tmr <= tmr - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[{cpage, widx}] <= pbuf[widx];
        end
    end

    assert_commit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !busy_o);
    assert_push_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !busy_o);
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom #(
    parameter logic [2:0] DEV_SEL    = 3'b000,
    parameter int         PAGE_W     = 8,
    parameter int         OFF_W      = 6,
    parameter int         MEM_PAGE_W = 4,
    parameter int         WR_CYCLES  = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_low_o
);
    logic scl_q, scl_rise, scl_fall;
    logic sda_q, sda_rise, sda_fall;
    logic start_c, stop_c;
    logic busy, push, clear, commit;
    logic [MEM_PAGE_W-1:0] page;
    logic [OFF_W-1:0]      off, push_off;
    logic [7:0]            push_data, rd_data;

    i2cpe_sync u_scl (.clk(clk), .rst_n(rst_n), .d(scl_i),
                      .q(scl_q), .rise(scl_rise), .fall(scl_fall));
    i2cpe_sync u_sda (.clk(clk), .rst_n(rst_n), .d(sda_i),
                      .q(sda_q), .rise(sda_rise), .fall(sda_fall));

    assign start_c = scl_q && !scl_rise && sda_fall;
    assign stop_c  = scl_q && !scl_rise && sda_rise;

    i2cpe_link #(.DEV_SEL(DEV_SEL), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
                 .STORE_PW(MEM_PAGE_W)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda(sda_q), .start_c(start_c), .stop_c(stop_c), .wp_i(wp_i),
        .busy_i(busy), .rd_data_i(rd_data), .sda_low_o(sda_low_o),
        .page_o(page), .off_o(off), .push_o(push), .push_off_o(push_off),
        .push_data_o(push_data), .clear_o(clear), .commit_o(commit));

    i2cpe_store #(.OFF_W(OFF_W), .MEM_PAGE_W(MEM_PAGE_W),
                  .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_off_i(push_off),
        .push_data_i(push_data), .clear_i(clear), .commit_i(commit),
        .page_i(page), .off_i(off), .rd_data_o(rd_data), .busy_o(busy));
endmodule

// File: tb/i2c_page_eeprom_tb.sv
module i2c_page_eeprom_tb;
    localparam int QP = 8;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, m_low = 1'b0, wp = 1'b0;
    logic sda_low;
    wire  sda_line = ~(m_low | sda_low);

    always #10 clk = ~clk;

    i2c_page_eeprom u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m),
                           .sda_i(sda_line), .wp_i(wp), .sda_low_o(sda_low));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_q[$], act_q[$];
    string      tag_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor: compares read bytes in order
    always begin : monitor
        logic [7:0] a, e;
        string t;
        wait (act_q.size() != 0);
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, a, e);
    end

    task automatic qwait();
        repeat (QP) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 0; qwait(); scl_m = 1; qwait(); m_low = 1; qwait(); scl_m = 0; qwait();
    endtask

    task automatic bus_stop();
        m_low = 1; qwait(); scl_m = 1; qwait(); m_low = 0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
        end
        m_low = 0; qwait(); scl_m = 1; qwait(); ack = (sda_line == 1'b0); qwait();
        scl_m = 0; qwait();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        m_low = 0;
        for (int i = 0; i < 8; i++) begin
            qwait(); scl_m = 1; qwait(); b = {b[6:0], sda_line}; qwait(); scl_m = 0; qwait();
        end
        qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
    endtask

    task automatic send_hdr(input int pg, input int off, input logic [1:0] junk, input string tag);
        logic [7:0] p;
        bit ack;
        p = 8'(pg);
        send_byte(8'hA0, ack); check(ack, tag, ack, 1);
        send_byte({junk, p[7:2]}, ack); check(ack, tag, ack, 1);
        send_byte({p[1:0], 6'(off)}, ack); check(ack, tag, ack, 1);
    endtask

    task automatic put(input logic [7:0] b, input bit exp_ack, input string tag);
        bit ack;
        send_byte(b, ack);
        check(ack == exp_ack, tag, ack, exp_ack);
    endtask

    // Returns the number of polls refused before an acknowledge
    task automatic poll(output int refused);
        bit ack;
        refused = 0;
        for (int i = 0; i < 20; i++) begin
            bus_start(); send_byte(8'hA0, ack); bus_stop();
            if (ack) break;
            refused++;
        end
    endtask

    task automatic end_write(input bit expect_busy, input string tag);
        int r;
        bus_stop();
        poll(r);
        if (expect_busy) check(r >= 1 && r < 20, tag, r, 1);
        else             check(r == 0, tag, r, 0);
    endtask

    task automatic rnd_read(input int pg, input int off, input logic [7:0] exp, input string tag);
        logic [7:0] b;
        bit ack;
        bus_start(); send_hdr(pg, off, 2'b00, tag);
        bus_start(); send_byte(8'hA1, ack); check(ack, "R11", ack, 1);
        recv_byte(b); bus_stop();
        exp_q.push_back(exp); tag_q.push_back(tag); act_q.push_back(b);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        bit ack;
        int r;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check(sda_low == 1'b0, "R1", sda_low, 0);
        rnd_read(0, 0, 8'hFF, "R1");
        rnd_read(15, 63, 8'hFF, "R1");

        // R2: non-matching addresses
        bus_start(); send_byte(8'hA2, ack); bus_stop(); check(!ack, "R2", ack, 0);
        bus_start(); send_byte(8'hB0, ack); bus_stop(); check(!ack, "R2", ack, 0);

        // R5: data then repeated START: not committed
        bus_start(); send_hdr(3, 5, 2'b00, "R3"); put(8'hA5, 1, "R3");
        bus_start(); send_byte(8'hA0, ack); check(ack, "R5", ack, 1);
        send_byte(8'h00, ack); send_byte(8'hC5, ack);
        bus_start(); send_byte(8'hA1, ack); check(ack, "R5", ack, 1);
        begin
            logic [7:0] b;
            recv_byte(b); bus_stop();
            exp_q.push_back(8'hFF); tag_q.push_back("R5"); act_q.push_back(b);
        end
        poll(r); check(r == 0, "R5", r, 0);

        // Byte write committed on STOP, busy polling (R8)
        bus_start(); send_hdr(3, 5, 2'b00, "R3"); put(8'hA5, 1, "R3");
        bus_stop();
        bus_start(); send_byte(8'hA1, ack); bus_stop(); check(!ack, "R8", ack, 0);
        poll(r); check(r < 20, "R8", r, 1);
        rnd_read(3, 5, 8'hA5, "R5");

        // R4: ignored high bits; R7: neighbours kept
        bus_start(); send_hdr(9, 7, 2'b11, "R4"); put(8'h5A, 1, "R4"); end_write(1, "R8");
        bus_start(); send_hdr(9, 8, 2'b00, "R7"); put(8'h77, 1, "R7"); end_write(1, "R8");
        rnd_read(9, 7, 8'h5A, "R4");
        rnd_read(9, 8, 8'h77, "R7");
        rnd_read(9, 9, 8'hFF, "R7");

        // R6: wrap within page
        bus_start(); send_hdr(2, 62, 2'b00, "R6");
        put(8'h11, 1, "R6"); put(8'h22, 1, "R6"); put(8'h33, 1, "R6"); put(8'h44, 1, "R6");
        end_write(1, "R8");
        rnd_read(2, 62, 8'h11, "R6");
        rnd_read(2, 63, 8'h22, "R6");
        rnd_read(2, 0, 8'h33, "R6");
        rnd_read(2, 1, 8'h44, "R6");
        rnd_read(3, 0, 8'hFF, "R6");

        // R6: 65 bytes, later byte wins at offset 0
        bus_start(); send_hdr(5, 0, 2'b00, "R6");
        for (int i = 0; i < 65; i++) put(8'(i + 1), 1, "R3");
        end_write(1, "R8");
        rnd_read(5, 0, 8'h41, "R6");
        rnd_read(5, 1, 8'h02, "R6");
        rnd_read(5, 63, 8'h40, "R6");

        // R9: protected write refused
        wp = 1;
        bus_start(); send_hdr(4, 0, 2'b00, "R9"); put(8'h99, 0, "R9");
        end_write(0, "R9");
        wp = 0;
        rnd_read(4, 0, 8'hFF, "R9");

        // R10: protect raised after capture has no effect
        bus_start(); send_hdr(4, 1, 2'b00, "R10"); put(8'h12, 1, "R10");
        wp = 1; put(8'h34, 1, "R10");
        end_write(1, "R10");
        wp = 0;
        rnd_read(4, 1, 8'h12, "R10");
        rnd_read(4, 2, 8'h34, "R10");

        // R12: header only, no write cycle
        bus_start(); send_hdr(6, 0, 2'b00, "R12"); end_write(0, "R12");
        rnd_read(6, 0, 8'hFF, "R12");

        wait (act_q.size() == 0);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule